// File: doc/BRIEF.md
# Serial EEPROM Power-On Configuration Loader

When reset is released, this block reads a fixed region at the start of a serial EEPROM over a two-wire, open-drain bus. It acts as the bus master and needs no software. The first eight bytes go into a configuration register. The ninth byte is a checksum over those eight. The block compares it and flags a mismatch. The next eight bytes are a six-byte station address followed by its two checksum bytes. They go into a holding register that a local bus reads one byte at a time. The block stores the address checksum but never checks it.

The whole load is one sequential read, with the order of operations on the bus as follows:
1. START.
2. The device address with the write bit.
3. Word address 0x00.
4. A repeated START.
5. The device address with the read bit.
6. Seventeen data bytes. The master acknowledges every data byte except the last, which it does not acknowledge.
7. STOP.

If the device does not acknowledge one of the three address bytes, the load is abandoned. The block then reports that no EEPROM is present and keeps its reset configuration. The `done` output rises when the load ends, whether it succeeded or failed. Until then the host sees only the reset configuration and zero from the local bus.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held: `scl_o` is 1, `sda_oe` is 0, and `done`, `cksum_err` and `no_eeprom` are 0. In addition, `cfg_o` equals `CFG_DEFAULT` and `lb_rdata` is 0.
- R2: The bus traffic runs in this order:
  - START;
  - written byte `{DEV_ADDR,0}` (0xA0 by default);
  - written byte 0x00;
  - repeated START;
  - written byte `{DEV_ADDR,1}` (0xA1);
  - the data bytes;
  - exactly one STOP.

  Bytes go MSB first. During the acknowledge slot of each byte it writes, the master releases SDA.
- R3: SDA never changes in the same clock as SCL. While SCL is high, SDA changes only to form a START (falling) or a STOP (rising).
- R4: Every low phase of SCL lasts exactly 2*DIV clock cycles.
- R5: After `done`, configuration byte i (EEPROM offset i, i = 0..7) appears on `cfg_o[8i+7:8i]`, whatever the checksum result.
- R6: Checksum result:
  - If bytes 0..8 sum to 0 modulo 256, both `cksum_err` and `no_eeprom` stay 0.
  - Otherwise both flags are 1 at `done`.
  - `cksum_err` is never 1 without `no_eeprom`.
- R7: After `done`, `lb_rdata` with `lb_sel` = k (k = 0..7) returns EEPROM byte 9+k. Any values in bytes 15 and 16 (the address checksum) leave both flags clear.
- R8: If the device does not acknowledge any of the three address bytes:
  - the master sends STOP and reads no data;
  - `done` rises with `no_eeprom` = 1 and `cksum_err` = 0;
  - `cfg_o` stays `CFG_DEFAULT`, and `lb_rdata` returns 0 for every `lb_sel`.
- R9: Once `done` is 1 it stays 1 until reset. Before `done`, `cfg_o` equals `CFG_DEFAULT` and `lb_rdata` is 0.
- R10: A full load reads exactly 17 data bytes (offsets 0x00..0x10). The master acknowledges the first 16 and not the 17th. No byte at offset 0x11 or above is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the load starts when it is released |
| scl_o | output | 1 | Serial clock level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Level sensed on the data line |
| lb_sel | input | $clog2(ADR_BYTES) | Local-bus byte select into the station address holding register |
| lb_rdata | output | 8 | Selected holding-register byte, or 0 before `done` |
| cfg_o | output | 8*CFG_BYTES | Configuration register, byte i at bits [8i+7:8i] |
| cksum_err | output | 1 | Configuration checksum mismatch |
| no_eeprom | output | 1 | No valid EEPROM: missing acknowledge or checksum mismatch |
| done | output | 1 | Load finished |

## Verification
The loader is run against a behavioural EEPROM with several images:
- A spread of nonzero configuration bytes with a correct checksum.
- The same image with the checksum off by one, which separates a real sum compare from a constant result.
- An all-zero configuration together with a deliberately wrong address checksum, which shows that only the configuration group is verified.
- An all-0xFF configuration, whose sum wraps modulo 256.

Three further runs withhold the acknowledge on each address byte in turn. They show that the abort happens at the correct point, that no data is read, and that the reset configuration survives.

Bytes placed at offsets 0x11 and above show whether the read goes past its end. Throughout every run, the bench measures bus edge ordering and SCL low-phase length.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    typedef enum logic [1:0] {
        TW_START,
        TW_STOP,
        TW_WRITE,
        TW_READ
    } tw_cmd_e;

    typedef enum logic [2:0] {
        SQ_START1,
        SQ_DEVW,
        SQ_WADDR,
        SQ_START2,
        SQ_DEVR,
        SQ_DATA,
        SQ_STOP,
        SQ_FIN
    } seq_st_e;

endpackage

// File: rtl/tw_phy.sv
module tw_phy
    import cfg_ldr_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  tw_cmd_e    cmd,
    input  logic [7:0] wdata,
    input  logic       last,
    output logic       done,
    output logic       ack_ok,
    output logic [7:0] rdata,
    output logic       scl_o,
    output logic       sda_oe,
    input  logic       sda_i
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic          busy;
        tw_cmd_e       cmd;
        logic          last;
        logic [DW-1:0] div;
        logic [1:0]    qt;
        logic [3:0]    bitn;
        logic [7:0]    sh;
        logic          scl;
        logic          sda_oe;
        logic          ack;
        logic          done;
    } phy_s;

    phy_s       q, d;
    logic       enter;
    logic [1:0] nq;

    // Each bit is four quarters of DIV clocks:
    // quarters 0 and 1 with SCL low, quarters 2 and 3 with SCL high.
    // SDA moves on entering quarter 1 (SCL already low) or quarter 3 (START/STOP only).
    always_comb begin
        d      = q;
        d.done = 1'b0;
        enter  = 1'b0;
        nq     = q.qt;
        if (!q.busy) begin
            if (cmd_valid) begin
                d.busy = 1'b1;
                d.cmd  = cmd;
                d.sh   = wdata;
                d.last = last;
                d.div  = '0;
                d.qt   = 2'd0;
                d.bitn = 4'd0;
                d.ack  = 1'b0;
                enter  = 1'b1;
                nq     = 2'd0;
            end
        end else if (q.div != DW'(DIV - 1)) begin
            d.div = q.div + 1'b1;
        end else begin
            d.div = '0;
            if (q.qt != 2'd3) begin
                d.qt  = q.qt + 2'd1;
                enter = 1'b1;
                nq    = q.qt + 2'd1;
            end else if (q.cmd == TW_START || q.cmd == TW_STOP || q.bitn == 4'd8) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.qt   = 2'd0;
                d.bitn = q.bitn + 4'd1;
                if (q.cmd == TW_WRITE) begin
                    d.sh = {q.sh[6:0], 1'b0};
                end
                enter = 1'b1;
                nq    = 2'd0;
            end
        end

        if (enter) begin
            case (nq)
                2'd0: d.scl = 1'b0;
                2'd1: begin
                    case (d.cmd)
                        TW_START: d.sda_oe = 1'b0;
                        TW_STOP:  d.sda_oe = 1'b1;
                        TW_WRITE: d.sda_oe = (d.bitn == 4'd8) ? 1'b0 : ~d.sh[7];
                        default:  d.sda_oe = (d.bitn == 4'd8) ? ~d.last : 1'b0;
                    endcase
                end
                2'd2: d.scl = 1'b1;
                default: begin
                    case (d.cmd)
                        TW_START: d.sda_oe = 1'b1;
                        TW_STOP:  d.sda_oe = 1'b0;
                        TW_WRITE: begin
                            if (d.bitn == 4'd8) d.ack = ~sda_i;
                        end
                        default: begin
                            if (d.bitn != 4'd8) d.sh = {d.sh[6:0], sda_i};
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.scl <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done   = q.done;
    assign ack_ok = q.ack;
    assign rdata  = q.sh;
    assign scl_o  = q.scl;
    assign sda_oe = q.sda_oe;

    AST_SDA_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl && $past(q.scl) && !$stable(q.sda_oe)) |-> (q.cmd == TW_START || q.cmd == TW_STOP)); // R3
    AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.scl) |-> $stable(q.sda_oe)); // R3
    AST_ACK_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cmd == TW_WRITE && q.bitn == 4'd8 && q.qt != 2'd0) |-> !q.sda_oe); // R2

endmodule

// File: rtl/ld_regs.sv
module ld_regs #(
    parameter int                     CFG_BYTES   = 8,
    parameter int                     ADR_BYTES   = 8,
    parameter logic [8*CFG_BYTES-1:0] CFG_DEFAULT = '0,
    parameter int                     TOTAL       = CFG_BYTES + 1 + ADR_BYTES,
    parameter int                     IW          = $clog2(TOTAL)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IW-1:0]                widx,
    input  logic [7:0]                   wdata,
    input  logic                         gate_open,
    input  logic [$clog2(ADR_BYTES)-1:0] lb_sel,
    output logic [8*CFG_BYTES-1:0]       cfg_o,
    output logic [7:0]                   lb_rdata,
    output logic                         sum_ok
);
    typedef struct packed {
        logic [CFG_BYTES-1:0][7:0] cfg;
        logic [ADR_BYTES-1:0][7:0] adr;
        logic [7:0]                sum;
    } reg_s;

    reg_s q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < CFG_BYTES; i++) begin
            if (we && widx == IW'(i)) d.cfg[i] = wdata;
        end
        for (int i = 0; i < ADR_BYTES; i++) begin
            if (we && widx == IW'(CFG_BYTES + 1 + i)) d.adr[i] = wdata;
        end
        // running sum covers configuration bytes and their checksum only
        if (we && widx <= IW'(CFG_BYTES)) d.sum = q.sum + wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cfg <= CFG_DEFAULT;
        end else begin
            q <= d;
        end
    end

    assign cfg_o    = gate_open ? q.cfg : CFG_DEFAULT;
    assign lb_rdata = gate_open ? q.adr[lb_sel] : 8'h00;
    assign sum_ok   = (q.sum == 8'h00);

    AST_WIDX_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (widx < IW'(TOTAL))); // R10
    AST_CFG_FROZEN_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate_open) && gate_open) |-> $stable(cfg_o)); // R9

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import cfg_ldr_pkg::*;
#(
    parameter int                     DIV         = 4,
    parameter logic [6:0]             DEV_ADDR    = 7'h50,
    parameter int                     CFG_BYTES   = 8,
    parameter int                     ADR_BYTES   = 8,
    parameter logic [8*CFG_BYTES-1:0] CFG_DEFAULT = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic                         scl_o,
    output logic                         sda_oe,
    input  logic                         sda_i,
    input  logic [$clog2(ADR_BYTES)-1:0] lb_sel,
    output logic [7:0]                   lb_rdata,
    output logic [8*CFG_BYTES-1:0]       cfg_o,
    output logic                         cksum_err,
    output logic                         no_eeprom,
    output logic                         done
);
    localparam int         TOTAL     = CFG_BYTES + 1 + ADR_BYTES;
    localparam int         IW        = $clog2(TOTAL);
    localparam logic [7:0] START_OFS = 8'h00;

    typedef struct packed {
        seq_st_e       st;
        logic [IW-1:0] idx;
        logic          wait_r;
        logic          abort;
        logic          done;
        logic          noe;
        logic          cke;
    } seq_s;

    seq_s       q, d;
    logic       cmd_valid;
    tw_cmd_e    cmd;
    logic [7:0] cmd_wdata;
    logic       cmd_last;
    logic       phy_done;
    logic       phy_ack;
    logic [7:0] phy_rdata;
    logic       st_we;
    logic       sum_ok;

    always_comb begin
        d         = q;
        cmd       = TW_STOP;
        cmd_wdata = 8'h00;
        cmd_last  = 1'b0;
        case (q.st)
            SQ_START1, SQ_START2: cmd = TW_START;
            SQ_DEVW: begin
                cmd       = TW_WRITE;
                cmd_wdata = {DEV_ADDR, 1'b0};
            end
            SQ_WADDR: begin
                cmd       = TW_WRITE;
                cmd_wdata = START_OFS;
            end
            SQ_DEVR: begin
                cmd       = TW_WRITE;
                cmd_wdata = {DEV_ADDR, 1'b1};
            end
            SQ_DATA: begin
                cmd      = TW_READ;
                cmd_last = (q.idx == IW'(TOTAL - 1));
            end
            default: cmd = TW_STOP;
        endcase

        cmd_valid = !q.wait_r && (q.st != SQ_FIN);
        st_we     = phy_done && (q.st == SQ_DATA);
        if (cmd_valid) d.wait_r = 1'b1;

        if (phy_done) begin
            d.wait_r = 1'b0;
            case (q.st)
                SQ_START1: d.st = SQ_DEVW;
                SQ_START2: d.st = SQ_DEVR;
                SQ_DEVW, SQ_WADDR, SQ_DEVR: begin
                    if (!phy_ack) begin
                        d.abort = 1'b1;
                        d.st    = SQ_STOP;
                    end else if (q.st == SQ_DEVW) begin
                        d.st = SQ_WADDR;
                    end else if (q.st == SQ_WADDR) begin
                        d.st = SQ_START2;
                    end else begin
                        d.st = SQ_DATA;
                    end
                end
                SQ_DATA: begin
                    if (q.idx == IW'(TOTAL - 1)) d.st = SQ_STOP;
                    else d.idx = q.idx + 1'b1;
                end
                SQ_STOP: d.st = SQ_FIN;
                default: d.st = SQ_FIN;
            endcase
        end

        if (q.st == SQ_FIN && !q.done) begin
            d.done = 1'b1;
            if (q.abort) begin
                d.noe = 1'b1;
            end else if (!sum_ok) begin
                d.noe = 1'b1;
                d.cke = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    tw_phy #(.DIV(DIV)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .wdata     (cmd_wdata),
        .last      (cmd_last),
        .done      (phy_done),
        .ack_ok    (phy_ack),
        .rdata     (phy_rdata),
        .scl_o     (scl_o),
        .sda_oe    (sda_oe),
        .sda_i     (sda_i)
    );

    ld_regs #(
        .CFG_BYTES   (CFG_BYTES),
        .ADR_BYTES   (ADR_BYTES),
        .CFG_DEFAULT (CFG_DEFAULT),
        .TOTAL       (TOTAL),
        .IW          (IW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (st_we),
        .widx      (q.idx),
        .wdata     (phy_rdata),
        .gate_open (q.done),
        .lb_sel    (lb_sel),
        .cfg_o     (cfg_o),
        .lb_rdata  (lb_rdata),
        .sum_ok    (sum_ok)
    );

    assign done      = q.done;
    assign no_eeprom = q.noe;
    assign cksum_err = q.cke;

    AST_CKERR_NEEDS_NOEEP: assert property (@(posedge clk) disable iff (!rst_n)
        q.cke |-> q.noe); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.done) |-> q.done); // R9
    AST_FLAG_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        q.noe |-> q.done); // R8
    AST_NO_DATA_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        q.abort |-> !st_we); // R8

endmodule

// File: tb/sim_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module sim_eeprom_cfg_loader;
    localparam int          DIV = 2;
    localparam logic [63:0] DEF = 64'hA5A5_5A5A_0F0F_F0F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl, m_oe, slv_oe, sda_bus;
    logic [2:0]  lb_sel = 3'd3;
    logic [7:0]  lb_rdata;
    logic [63:0] cfg;
    logic        ckerr, noe, done;

    always #2 clk = ~clk;

    assign sda_bus = ~m_oe & ~slv_oe;

    eeprom_cfg_loader #(.DIV(DIV), .CFG_DEFAULT(DEF)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_o(scl), .sda_oe(m_oe), .sda_i(sda_bus),
        .lb_sel(lb_sel), .lb_rdata(lb_rdata), .cfg_o(cfg),
        .cksum_err(ckerr), .no_eeprom(noe), .done(done)
    );

    int checks = 0;
    int errors = 0;

    // behavioural EEPROM and bus observer
    logic [7:0] mem [0:31];
    logic [7:0] wq [$];
    int         macks [$];
    int         nack_at, wbytes_n, bis, starts, stops, rd_bytes, cnt, ptr, lowlen;
    int         viol_joint, viol_low, viol_done;
    bit         active, rd_mode, pend_rd;
    logic [7:0] rsh, cur;
    logic       prev_scl, prev_sda, prev_done;

    task automatic model_clear(input int nk);
        wq.delete();
        macks.delete();
        nack_at = nk; wbytes_n = 0; bis = 0; starts = 0; stops = 0; rd_bytes = 0;
        cnt = 0; ptr = 0; lowlen = 0; viol_joint = 0; viol_low = 0; viol_done = 0;
        active = 0; rd_mode = 0; pend_rd = 0; rsh = 8'h00; cur = 8'h00;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            slv_oe    = 1'b0;
            prev_scl  = 1'b1;
            prev_sda  = 1'b1;
            prev_done = 1'b0;
        end else begin
            if (prev_done && !done) viol_done++;
            if (scl !== prev_scl && sda_bus !== prev_sda) viol_joint++;
            if (scl && prev_scl && prev_sda && !sda_bus) begin
                starts++; active = 1; cnt = 0; bis = 0; rd_mode = 0; slv_oe = 1'b0;
            end else if (scl && prev_scl && !prev_sda && sda_bus) begin
                stops++; active = 0; slv_oe = 1'b0;
            end else if (scl && !prev_scl) begin
                if (lowlen != 2 * DIV) viol_low++;
                if (active) begin
                    if (cnt < 8) rsh = {rsh[6:0], sda_bus};
                    else if (rd_mode) macks.push_back(sda_bus ? 0 : 1);
                    cnt++;
                end
            end else if (!scl && prev_scl && active) begin
                if (cnt == 8) begin
                    if (!rd_mode) begin
                        wq.push_back(rsh);
                        if (wbytes_n != nack_at) begin
                            slv_oe = 1'b1;
                            if (bis == 0 && rsh[0]) pend_rd = 1;
                            if (bis == 1) ptr = int'(rsh[4:0]);
                        end
                        wbytes_n++;
                        bis++;
                    end else begin
                        slv_oe = 1'b0;
                    end
                end else if (cnt == 9) begin
                    cnt = 0;
                    slv_oe = 1'b0;
                    if (pend_rd || (rd_mode && macks.size() > 0 && macks[$] == 1)) begin
                        rd_mode = 1; pend_rd = 0;
                        cur = mem[ptr]; ptr++; rd_bytes++;
                        slv_oe = ~cur[7];
                    end else if (rd_mode) begin
                        active = 0;
                    end
                end else if (rd_mode && cnt >= 1 && cnt <= 7) begin
                    slv_oe = ~cur[7-cnt];
                end
            end
            lowlen = scl ? 0 : lowlen + 1;
            prev_scl  = scl;
            prev_sda  = sda_bus;
            prev_done = done;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input int kind);
        int s;
        for (int i = 0; i < 32; i++) mem[i] = 8'hEE;
        s = 0;
        for (int i = 0; i < 8; i++) begin
            case (kind)
                2: mem[i] = 8'h00;
                3: mem[i] = 8'hFF;
                default: mem[i] = 8'((i * 8'h35) + 8'h17);
            endcase
            s += int'(mem[i]);
        end
        mem[8] = 8'((256 - (s % 256)) % 256);
        if (kind == 1) mem[8] = mem[8] + 8'h01;
        for (int i = 9; i < 17; i++) mem[i] = 8'(8'hC0 + i * 3);
        if (kind == 2) begin
            mem[15] = 8'h12;
            mem[16] = 8'h34;
        end
    endtask

    function automatic logic [63:0] cfg_img();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = mem[i];
        return v;
    endfunction

    task automatic run_load(input string tag, input int kind, input int nk);
        int  n;
        bit  mid;
        int  s;
        bit  bad;
        fill(kind);
        rst_n = 1'b0;
        model_clear(nk);
        lb_sel = 3'd3;
        repeat (3) @(negedge clk);
        chk({"R1 scl ", tag}, 64'(scl), 64'd1);
        chk({"R1 sda_oe ", tag}, 64'(m_oe), 64'd0);
        chk({"R1 flags/done ", tag}, {61'd0, done, noe, ckerr}, 64'd0);
        chk({"R1 cfg ", tag}, cfg, DEF);
        chk({"R1 lb ", tag}, 64'(lb_rdata), 64'd0);
        rst_n = 1'b1;
        n = 0; mid = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (!mid && rd_bytes == 10) begin
                mid = 1;
                chk({"R9 cfg held ", tag}, cfg, DEF);
                chk({"R9 lb held ", tag}, 64'(lb_rdata), 64'd0);
            end
        end
        chk({"R9 done reached ", tag}, 64'(done), 64'd1);
        repeat (20) @(negedge clk);
        chk({"R9 done sticky ", tag}, 64'(viol_done), 64'd0);
        chk({"R3 joint edges ", tag}, 64'(viol_joint), 64'd0);
        chk({"R4 scl low length ", tag}, 64'(viol_low), 64'd0);
        chk({"R2 stops ", tag}, 64'(stops), 64'd1);
        if (nk < 0) begin
            s = 0;
            for (int i = 0; i < 9; i++) s += int'(mem[i]);
            bad = (s % 256) != 0;
            chk({"R2 starts ", tag}, 64'(starts), 64'd2);
            chk({"R2 written bytes ", tag},
                (wq.size() == 3) ? {40'd0, wq[0], wq[1], wq[2]} : 64'hDEAD,
                {40'd0, 8'hA0, 8'h00, 8'hA1});
            chk({"R10 data count ", tag}, 64'(rd_bytes), 64'd17);
            chk({"R10 ack count ", tag}, 64'(macks.size()), 64'd17);
            s = 0;
            for (int i = 0; i < macks.size(); i++) s += macks[i];
            chk({"R10 acks given ", tag}, 64'(s), 64'd16);
            chk({"R10 last nack ", tag}, (macks.size() > 0) ? 64'(macks[$]) : 64'd9, 64'd0);
            chk({"R5 cfg ", tag}, cfg, cfg_img());
            chk({"R6 cksum_err ", tag}, 64'(ckerr), 64'(bad));
            chk({"R6 no_eeprom ", tag}, 64'(noe), 64'(bad));
            for (int k = 0; k < 8; k++) begin
                lb_sel = 3'(k);
                #1;
                chk({"R7 lb byte ", tag}, 64'(lb_rdata), 64'(mem[9+k]));
            end
        end else begin
            chk({"R8 starts ", tag}, 64'(starts), (nk == 2) ? 64'd2 : 64'd1);
            chk({"R8 written count ", tag}, 64'(wq.size()), 64'(nk + 1));
            chk({"R8 no data ", tag}, 64'(rd_bytes), 64'd0);
            chk({"R8 no_eeprom ", tag}, 64'(noe), 64'd1);
            chk({"R8 cksum_err ", tag}, 64'(ckerr), 64'd0);
            chk({"R8 cfg default ", tag}, cfg, DEF);
            for (int k = 0; k < 8; k++) begin
                lb_sel = 3'(k);
                #1;
                chk({"R8 lb zero ", tag}, 64'(lb_rdata), 64'd0);
            end
        end
    endtask

    initial begin
        model_clear(-1);
        run_load("good", 0, -1);
        run_load("badsum", 1, -1);
        run_load("zero_badaddrsum", 2, -1);
        run_load("allff", 3, -1);
        run_load("nack_devw", 0, 0);
        run_load("nack_word", 0, 1);
        run_load("nack_devr", 0, 2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule